// File: doc/BRIEF.md
# Serial-to-Parallel Bus Bridge

This block lets a small controller with few spare pins drive a parallel data byte and a two-byte address onto a wide bus. The controller clocks bits into a serial chain, most significant bit first. A complete write frame is three bytes long. The data byte goes first, then the low address byte, then the high address byte. A separate active-low strobe then copies the whole chain into the output registers in one step. Each of the two buses has its own active-low enable. While an enable is high, the matching outputs float.

For reads, a second active-low strobe captures a parallel input byte into a read-back register. The controller then reads that byte one bit at a time on a serial output, most significant bit first, using the same bit clock. The bit clock, the serial data line and both strobes are asynchronous to the system clock. Each one passes through a flop synchronizer, and its edges are detected in the system clock domain.

Top module: `serial_bus_bridge`

## Requirements
- R1: After reset the serial output is 0 and, with both enables low, the data and both address outputs read 0.
- R2: Bits are taken on each rising edge of the bit clock, which idles high. After 24 bits and a low pulse on the write strobe, the data output holds the first byte sent, the low address output the second and the high address output the third, each sent MSB first.
- R3: The output registers keep their values while further bits are shifted in, until the next write strobe pulse.
- R4: While the address enable is high, both address outputs are high impedance. While it is low, they drive the latched address.
- R5: The data enable works independently of the address enable. While it is high, the data output is high impedance. While it is low, the data output drives the latched data.
- R6: A low pulse on the read strobe loads the parallel input byte, and the serial output then shows bit 7 of that byte.
- R7: Each later rising edge of the bit clock moves the serial output to the next lower bit. Zeros fill in from below, so after eight edges the output is 0.
- R8: When more than 24 bits are sent before a strobe, only the last 24 bits reach the outputs. The oldest bits drop out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Bit clock, idles high, async |
| ser_din | input | 1 | Serial write data, async |
| wr_stb_n | input | 1 | Active-low latch strobe, async |
| rd_stb_n | input | 1 | Active-low read capture strobe, async |
| addr_oe_n | input | 1 | Active-low address output enable |
| data_oe_n | input | 1 | Active-low data output enable |
| rd_byte | input | BYTE_W | Parallel byte captured for read-back |
| ser_dout | output | 1 | Serial read-back data |
| addr_hi | output | BYTE_W | High address byte, tri-state |
| addr_lo | output | BYTE_W | Low address byte, tri-state |
| data_bus | output | BYTE_W | Data byte, tri-state |

## Verification
The bench uses the defaults: BYTE_W of 8 and SYNC_STAGES of 2. With this configuration all 256 read-back bytes can be swept, and every bit position is checked as it shifts out. Write frames are built arithmetically from a loop index, so each bit of each slot toggles across the sweep. The float cases are observed on pulled-up nets, so a released bus reads all ones.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum int {SLOT_DATA = 0, SLOT_ALO = 1, SLOT_AHI = 2} slot_e;

  localparam int NUM_SLOTS = 3;

  // bit offset of a slot inside the frame chain: data was sent first,
  // so it has travelled furthest and sits at the top
  function automatic int slot_base(input slot_e s, input int bw);
    return (NUM_SLOTS - 1 - int'(s)) * bw;
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= IDLE;
          else        stage_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= IDLE;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import bridge_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  input  logic              latch_en,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] alo_o,
  output logic [BYTE_W-1:0] ahi_o
);
  localparam int FRAME_W = NUM_SLOTS * BYTE_W;

  logic [FRAME_W-1:0] chain_q;
  logic [NUM_SLOTS-1:0][BYTE_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        chain_q <= '0;
    else if (shift_en) chain_q <= {chain_q[FRAME_W-2:0], bit_i};

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam int BASE = slot_base(slot_e'(s), BYTE_W);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        lat_q[s] <= '0;
        else if (latch_en) lat_q[s] <= chain_q[BASE +: BYTE_W];
    end
  endgenerate

  assign data_o = lat_q[SLOT_DATA];
  assign alo_o  = lat_q[SLOT_ALO];
  assign ahi_o  = lat_q[SLOT_AHI];
endmodule

// File: rtl/readback_shifter.sv
module readback_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift_en,
  output logic              bit_o
);
  logic [BYTE_W-1:0] rb_q;

  // a capture takes priority over a shift in the same cycle
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        rb_q <= '0;
    else if (load_en)  rb_q <= load_val;
    else if (shift_en) rb_q <= {rb_q[BYTE_W-2:0], 1'b0};

  assign bit_o = rb_q[BYTE_W-1];
endmodule

// File: rtl/serial_bus_bridge.sv
module serial_bus_bridge #(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              wr_stb_n,
  input  logic              rd_stb_n,
  input  logic              addr_oe_n,
  input  logic              data_oe_n,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              ser_dout,
  output logic [BYTE_W-1:0] addr_hi,
  output logic [BYTE_W-1:0] addr_lo,
  output logic [BYTE_W-1:0] data_bus
);
  localparam int NSIG = 4;
  localparam int I_SCLK = 0;
  localparam int I_DIN  = 1;
  localparam int I_WR   = 2;
  localparam int I_RD   = 3;
  // idle levels: bit clock and strobes high, data low
  localparam logic [NSIG-1:0] IDLE = 4'b1101;

  logic [NSIG-1:0] raw, lvl;
  logic sclk_prev, wr_prev, rd_prev;
  logic bit_rise, wr_fall, rd_fall, din_s;
  logic [BYTE_W-1:0] data_q, alo_q, ahi_q;

  assign raw = {rd_stb_n, wr_stb_n, ser_din, ser_clk};

  sync_chain #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .IDLE(IDLE)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(lvl)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_prev <= 1'b1;
      wr_prev   <= 1'b1;
      rd_prev   <= 1'b1;
    end else begin
      sclk_prev <= lvl[I_SCLK];
      wr_prev   <= lvl[I_WR];
      rd_prev   <= lvl[I_RD];
    end

  // named event wires
  assign bit_rise = lvl[I_SCLK] & ~sclk_prev;
  assign wr_fall  = ~lvl[I_WR] & wr_prev;
  assign rd_fall  = ~lvl[I_RD] & rd_prev;
  assign din_s    = lvl[I_DIN];

  frame_shifter #(.BYTE_W(BYTE_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_rise), .bit_i(din_s),
    .latch_en(wr_fall), .data_o(data_q), .alo_o(alo_q), .ahi_o(ahi_q)
  );

  readback_shifter #(.BYTE_W(BYTE_W)) rback_i (
    .clk(clk), .rst_n(rst_n), .load_en(rd_fall), .load_val(rd_byte),
    .shift_en(bit_rise), .bit_o(ser_dout)
  );

  assign addr_hi  = addr_oe_n ? {BYTE_W{1'bz}} : ahi_q;
  assign addr_lo  = addr_oe_n ? {BYTE_W{1'bz}} : alo_q;
  assign data_bus = data_oe_n ? {BYTE_W{1'bz}} : data_q;
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_rise,
  input logic              wr_fall,
  input logic              rd_fall,
  input logic              din_s,
  input logic [BYTE_W-1:0] rd_byte,
  input logic              ser_dout,
  input logic [BYTE_W-1:0] data_q,
  input logic [BYTE_W-1:0] alo_q,
  input logic [BYTE_W-1:0] ahi_q
);
  localparam int FW = 3 * BYTE_W;

  // independent shadows of the serial streams
  logic [FW-1:0] shadow_frame;
  logic [BYTE_W-1:0] shadow_rb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shadow_frame <= '0;
      shadow_rb    <= '0;
    end else begin
      if (bit_rise) shadow_frame <= {shadow_frame[FW-2:0], din_s};
      if (rd_fall)       shadow_rb <= rd_byte;
      else if (bit_rise) shadow_rb <= shadow_rb << 1;
    end

  assert_latch_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> {data_q, alo_q, ahi_q} == $past(shadow_frame));

  assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fall |=> ($stable(data_q) && $stable(alo_q) && $stable(ahi_q)));

  assert_capture_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |=> ser_dout == $past(rd_byte[BYTE_W-1]));

  assert_shift_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_rise && !rd_fall) |=> ser_dout == $past(shadow_rb[BYTE_W-2]));
endmodule

bind serial_bus_bridge bridge_checker #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .wr_fall(wr_fall),
  .rd_fall(rd_fall), .din_s(din_s), .rd_byte(rd_byte), .ser_dout(ser_dout),
  .data_q(data_q), .alo_q(alo_q), .ahi_q(ahi_q)
);

// File: tb/serial_bus_bridge_tb.sv
module serial_bus_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int HB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, din = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic aoe_n = 1'b0, doe_n = 1'b0;
  logic [BW-1:0] rbyte = '0;
  logic dout;
  tri1 [BW-1:0] ah_w, al_w, d_w;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_bus_bridge #(.BYTE_W(BW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_din(din),
    .wr_stb_n(wr_n), .rd_stb_n(rd_n), .addr_oe_n(aoe_n), .data_oe_n(doe_n),
    .rd_byte(rbyte), .ser_dout(dout),
    .addr_hi(ah_w), .addr_lo(al_w), .data_bus(d_w)
  );

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    din = b; sclk = 1'b0;
    repeat (HB) @(negedge clk);
    sclk = 1'b1;
    repeat (HB) @(negedge clk);
  endtask

  task automatic send_byte(input logic [BW-1:0] v);
    for (int i = BW-1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_wr();
    @(negedge clk); wr_n = 1'b0;
    repeat (HB) @(negedge clk); wr_n = 1'b1;
    repeat (HB) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_n = 1'b0;
    repeat (HB) @(negedge clk); rd_n = 1'b1;
    repeat (HB) @(negedge clk);
  endtask

  task automatic check_buses(input string tag, input logic [BW-1:0] d,
                             input logic [BW-1:0] lo, input logic [BW-1:0] hi);
    chk({tag, " data"}, d_w, d);
    chk({tag, " alo"}, al_w, lo);
    chk({tag, " ahi"}, ah_w, hi);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [BW-1:0] d, lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk("R1 dout", {7'd0, dout}, 8'h00);
    check_buses("R1", 8'h00, 8'h00, 8'h00);

    // R2: write frames swept over computed patterns
    for (int k = 0; k < 16; k++) begin
      d  = 8'(k * 17) ^ 8'h5A;
      lo = 8'(k * 29 + 3);
      hi = ~8'(k * 13);
      send_byte(d); send_byte(lo); send_byte(hi);
      pulse_wr();
      check_buses("R2", d, lo, hi);
    end

    // R3: shift a new frame without a strobe, outputs keep last latch
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    check_buses("R3", d, lo, hi);
    pulse_wr();
    check_buses("R3 after strobe", 8'h11, 8'h22, 8'h33);

    // R8: 32 bits before the strobe, first byte dropped
    send_byte(8'hE7); send_byte(8'h3C); send_byte(8'hA5); send_byte(8'h0F);
    pulse_wr();
    check_buses("R8", 8'h3C, 8'hA5, 8'h0F);

    // R4 and R5: independent enables (released nets pull up to ff)
    @(negedge clk); aoe_n = 1'b1; doe_n = 1'b0;
    @(negedge clk);
    check_buses("R4 addr off", 8'h3C, 8'hFF, 8'hFF);
    aoe_n = 1'b0; doe_n = 1'b1;
    @(negedge clk);
    check_buses("R5 data off", 8'hFF, 8'hA5, 8'h0F);
    aoe_n = 1'b1; doe_n = 1'b1;
    @(negedge clk);
    check_buses("R4 R5 both off", 8'hFF, 8'hFF, 8'hFF);
    aoe_n = 1'b0; doe_n = 1'b0;
    @(negedge clk);
    check_buses("R4 R5 both on", 8'h3C, 8'hA5, 8'h0F);

    // R6 and R7: exhaustive read-back sweep
    for (int v = 0; v < 256; v++) begin
      rbyte = 8'(v);
      pulse_rd();
      rbyte = ~8'(v);
      chk("R6 msb", {7'd0, dout}, {7'd0, v[7]});
      for (int b = BW-2; b >= 0; b--) begin
        send_bit(1'b1);
        chk("R7 bit", {7'd0, dout}, {7'd0, v[b]});
      end
      send_bit(1'b1);
      chk("R7 fill", {7'd0, dout}, 8'h00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule